// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache with Line Refill

This block sits between an instruction fetch stage and a slower next-level memory. A fetch stage presents a request on a valid/ready channel: a byte address, a write flag and a 32-bit write word. Some cycles later the block answers on a valid/ready response channel with a 32-bit word and a flag that says whether the lookup hit. The storage is a direct-mapped array of sixteen lines. Each line holds one valid bit, one tag and one data word.

A read that finds a valid line with a matching tag is answered from the array. A read that misses sends a single word request to the next-level port, waits for that port's answer, writes the word into the line and then returns it with the hit flag low. After a miss, the same address hits, so a cold start does not keep missing. A write request fills the addressed line directly and never goes to the next level. Only one request is in flight at a time.

Top module: `ifetch_dm_cache`

## Requirements
- R1: Reset is synchronous and active high. While and after reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. Every line is invalid, so the first read of any address after reset misses.
- R2: A read accepted while its line is valid and its tag (address bits [31:6]) matches is answered with `rsp_valid` high in the cycle after acceptance. The answer has `rsp_hit`=1, carries the stored word and raises no next-level request.
- R3: A read that misses raises `mem_req_valid` for exactly one cycle, in the cycle after acceptance. That request carries the request address with bits [1:0] cleared. The response follows in the cycle after `mem_rsp_valid` and carries `mem_rsp_data` with `rsp_hit`=0.
- R4: A refill writes the fetched word, the tag and a set valid bit into the line. A later read of the same address then hits, with no further next-level request.
- R5: The line index is address bits [5:2]. Two addresses with the same index and different tags (for example 28 and 92) evict each other, so each read of the other address misses again.
- R6: A write request stores the write word, sets the tag and sets the valid bit of its line. Its response arrives in the next cycle with data equal to the write word. `rsp_hit` on that response is 1 only if the line was already valid with the same tag. A write raises no next-level request.
- R7: `req_ready` is 0 from the cycle after an acceptance until the response has been taken. This includes the whole refill.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and `rsp_data` and `rsp_hit` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Byte address |
| req_wr | input | 1 | 1 = write the line, 0 = read |
| req_wdata | input | 32 | Word to write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 32 | Read word, or the written word |
| rsp_hit | output | 1 | Lookup found a valid matching line |
| mem_req_valid | output | 1 | One-cycle next-level word request |
| mem_req_addr | output | 32 | Word-aligned next-level address |
| mem_rsp_valid | input | 1 | Next-level word is present |
| mem_rsp_data | input | 32 | Next-level word |

## Verification
Read hits and writes must show `rsp_valid` in the cycle after acceptance. The bench checks this at the first falling edge after the accepting rising edge, and at that same edge it expects `mem_req_valid` high for a miss instead. For a miss, the bench memory model checks `rsp_valid` at the falling edge after the cycle in which it drove `mem_rsp_valid`, and checks that `req_ready` was low when the request appeared. A scoreboard pops each response when it is taken and compares its word, its hit flag and the running count of next-level requests. The sequence covers the 28/92 eviction, write hits, write misses, back-pressure and a reset in the middle of the run.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int unsigned IC_ADDR_W = 32;
    localparam int unsigned IC_DATA_W = 32;
    localparam int unsigned IC_LINES  = 16;
    localparam int unsigned IC_OFF_W  = $clog2(IC_DATA_W / 8);
    localparam int unsigned IC_IDX_W  = $clog2(IC_LINES);
    localparam int unsigned IC_TAG_W  = IC_ADDR_W - IC_IDX_W - IC_OFF_W;

    typedef logic [IC_ADDR_W-1:0] addr_t;
    typedef logic [IC_DATA_W-1:0] data_t;
    typedef logic [IC_IDX_W-1:0]  idx_t;
    typedef logic [IC_TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic  vld;
        tag_t  tag;
        data_t data;
    } line_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        tag_t  tag;
        data_t data;
    } fill_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } ctl_state_e;

    function automatic idx_t idx_of(addr_t a);
        return a[IC_OFF_W +: IC_IDX_W];
    endfunction

    function automatic tag_t tag_of(addr_t a);
        return a[IC_ADDR_W-1 -: IC_TAG_W];
    endfunction

endpackage

// File: rtl/ic_line_store.sv
module ic_line_store
    import icache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_idx,
    output line_t rd_line,
    input  fill_t wr
);

    line_t lines_q [IC_LINES];

    for (genvar g = 0; g < IC_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lines_q[g].vld <= 1'b0;
            end else if (wr.en && wr.idx == idx_t'(g)) begin
                lines_q[g].vld  <= 1'b1;
                lines_q[g].tag  <= wr.tag;
                lines_q[g].data <= wr.data;
            end
        end
    end

    always_comb rd_line = lines_q[rd_idx];

    // R1: the cycle after reset is released, no line may be valid yet
    logic rst_d;
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (!rst && rst_d) begin
            for (int i = 0; i < IC_LINES; i++) begin
                assert_reset_clears_R1: assert (!lines_q[i].vld)
                    else $error("line %0d valid right after reset", i);
            end
        end
    end

endmodule

// File: rtl/ic_lookup.sv
module ic_lookup
    import icache_pkg::*;
(
    input  addr_t addr,
    input  line_t line,
    output idx_t  idx,
    output logic  hit
);

    logic unused_off;
    assign unused_off = ^addr[IC_OFF_W-1:0];

    always_comb begin
        idx = idx_of(addr);
        hit = line.vld && (line.tag == tag_of(addr));
    end

endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
    import icache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    output logic  req_ready,
    input  addr_t req_addr,
    input  logic  req_wr,
    input  data_t req_wdata,
    input  logic  look_hit,
    input  data_t look_data,
    output logic  rsp_valid,
    input  logic  rsp_ready,
    output data_t rsp_data,
    output logic  rsp_hit,
    output logic  mem_req_valid,
    output addr_t mem_req_addr,
    input  logic  mem_rsp_valid,
    input  data_t mem_rsp_data,
    output fill_t fill
);

    ctl_state_e                      state_q;
    logic [IC_ADDR_W-1:IC_OFF_W]     waddr_q;
    data_t                           data_q;
    logic                            hit_q;
    logic                            accept;

    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_data      = data_q;
    assign rsp_hit       = hit_q;
    assign mem_req_valid = (state_q == ST_FETCH);
    assign mem_req_addr  = {waddr_q, {IC_OFF_W{1'b0}}};

    always_comb begin
        fill = '0;
        if (accept && req_wr) begin
            fill.en   = 1'b1;
            fill.idx  = idx_of(req_addr);
            fill.tag  = tag_of(req_addr);
            fill.data = req_wdata;
        end else if (state_q == ST_WAIT && mem_rsp_valid) begin
            fill.en   = 1'b1;
            fill.idx  = waddr_q[IC_OFF_W +: IC_IDX_W];
            fill.tag  = waddr_q[IC_ADDR_W-1 -: IC_TAG_W];
            fill.data = mem_rsp_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            waddr_q <= '0;
            data_q  <= '0;
            hit_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        waddr_q <= req_addr[IC_ADDR_W-1:IC_OFF_W];
                        if (req_wr) begin
                            data_q  <= req_wdata;
                            hit_q   <= look_hit;
                            state_q <= ST_RESP;
                        end else if (look_hit) begin
                            data_q  <= look_data;
                            hit_q   <= 1'b1;
                            state_q <= ST_RESP;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        data_q  <= mem_rsp_data;
                        hit_q   <= 1'b0;
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: an accepted request closes the request channel in the next cycle
    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8: a stalled response keeps its contents
    assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_hit)));

    // R3: a read miss issues a next-level request in the following cycle, as a single pulse
    assert_miss_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_wr && !look_hit) |=> mem_req_valid);

    assert_fetch_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R3: the refilled word is answered in the next cycle as a miss
    assert_refill_answer_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && mem_rsp_valid) |=>
            (rsp_valid && !rsp_hit && rsp_data == $past(mem_rsp_data)));

    // R6: a write answers with its own word in the next cycle, with no next-level access
    assert_write_answer_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_wr) |=>
            (rsp_valid && !mem_req_valid && rsp_data == $past(req_wdata)));

endmodule

// File: rtl/ifetch_dm_cache.sv
module ifetch_dm_cache
    import icache_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [IC_ADDR_W-1:0] req_addr,
    input  logic                 req_wr,
    input  logic [IC_DATA_W-1:0] req_wdata,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [IC_DATA_W-1:0] rsp_data,
    output logic                 rsp_hit,
    output logic                 mem_req_valid,
    output logic [IC_ADDR_W-1:0] mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [IC_DATA_W-1:0] mem_rsp_data
);

    line_t rd_line;
    idx_t  rd_idx;
    logic  look_hit;
    fill_t fill;

    ic_lookup u_lookup (
        .addr (req_addr),
        .line (rd_line),
        .idx  (rd_idx),
        .hit  (look_hit)
    );

    ic_line_store u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rd_idx),
        .rd_line (rd_line),
        .wr      (fill)
    );

    ic_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_wr        (req_wr),
        .req_wdata     (req_wdata),
        .look_hit      (look_hit),
        .look_data     (rd_line.data),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_data      (rsp_data),
        .rsp_hit       (rsp_hit),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .fill          (fill)
    );

endmodule

// File: tb/ifetch_dm_cache_tb.sv
module ifetch_dm_cache_tb_top;
    import icache_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;
    localparam int WATCHDOG   = 20000;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  req_valid = 1'b0, req_ready, req_wr = 1'b0;
    addr_t req_addr = '0;
    data_t req_wdata = '0;
    logic  rsp_valid, rsp_ready = 1'b1, rsp_hit;
    data_t rsp_data;
    logic  mem_req_valid;
    addr_t mem_req_addr;
    logic  mem_rsp_valid = 1'b0;
    data_t mem_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int fetch_cnt = 0;
    addr_t last_addr = '0;

    data_t exp_data_q[$];
    logic  exp_hit_q[$];
    int    exp_fetch_q[$];
    string exp_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ifetch_dm_cache dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wr(req_wr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic data_t mem_word(addr_t a);
        return (a * 32'h0101_0101) ^ 32'hA5A5_0000;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // next-level memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                addr_t a;
                a = mem_req_addr;
                fetch_cnt++;
                check(a == {last_addr[31:2], 2'b00}, "R3", "next-level address", a, {last_addr[31:2], 2'b00});
                check(req_ready == 1'b0, "R7", "ready during refill", req_ready, 0);
                repeat (MEM_LAT) @(negedge clk);
                mem_rsp_data  = mem_word(a);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                check(rsp_valid == 1'b1, "R3", "response one cycle after refill", rsp_valid, 1);
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rsp_valid && rsp_ready) begin
                if (exp_data_q.size() == 0) begin
                    check(0, "R2", "unexpected response", rsp_data, 0);
                end else begin
                    data_t ed; logic eh; int ef; string et;
                    ed = exp_data_q.pop_front();
                    eh = exp_hit_q.pop_front();
                    ef = exp_fetch_q.pop_front();
                    et = exp_tag_q.pop_front();
                    check(rsp_data == ed, et, "response data", rsp_data, ed);
                    check(rsp_hit == eh, et, "hit flag", {31'd0, rsp_hit}, {31'd0, eh});
                    check(fetch_cnt == ef, et, "next-level request count", fetch_cnt, ef);
                end
            end
        end
    end

    task automatic issue(addr_t a, bit wr, data_t wd, data_t ed, bit eh, int ef, string tag);
        @(negedge clk);
        exp_data_q.push_back(ed);
        exp_hit_q.push_back(eh);
        exp_fetch_q.push_back(ef);
        exp_tag_q.push_back(tag);
        last_addr = a;
        req_addr  = a;
        req_wr    = wr;
        req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (wr || eh) begin
            check(rsp_valid == 1'b1, tag, "answer one cycle after acceptance", rsp_valid, 1);
            check(mem_req_valid == 1'b0, tag, "no next-level request", mem_req_valid, 0);
        end else begin
            check(mem_req_valid == 1'b1, "R3", "miss request one cycle after acceptance", mem_req_valid, 1);
        end
    endtask

    task automatic drain();
        while (exp_data_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "no response in reset", rsp_valid, 0);
        check(mem_req_valid == 1'b0, "R1", "no fetch in reset", mem_req_valid, 0);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 compulsory misses, R3 refill
        issue(32'd0,  0, '0, mem_word(32'd0),  0, 1, "R1");
        issue(32'd28, 0, '0, mem_word(32'd28), 0, 2, "R3");
        // R4 / R2 repeat reads hit
        issue(32'd0,  0, '0, mem_word(32'd0),  1, 2, "R4");
        issue(32'd28, 0, '0, mem_word(32'd28), 1, 2, "R2");
        // R5 conflict between 28 and 92
        issue(32'd92, 0, '0, mem_word(32'd92), 0, 3, "R5");
        issue(32'd28, 0, '0, mem_word(32'd28), 0, 4, "R5");
        issue(32'd92, 0, '0, mem_word(32'd92), 0, 5, "R5");
        // R3 unaligned byte address fetches the aligned word
        issue(32'd94, 0, '0, mem_word(32'd92), 1, 5, "R2");
        issue(32'd130, 0, '0, mem_word(32'd128), 0, 6, "R3");
        // R6 write to line 0 with a new tag (miss), then read it
        issue(32'h40, 1, 32'hDEAD_0001, 32'hDEAD_0001, 0, 6, "R6");
        issue(32'h40, 0, '0, 32'hDEAD_0001, 1, 6, "R6");
        issue(32'h00, 0, '0, mem_word(32'd0), 0, 7, "R5");
        // R6 write with matching tag reports a hit
        issue(32'h00, 1, 32'hCAFE_0002, 32'hCAFE_0002, 1, 7, "R6");
        issue(32'h00, 0, '0, 32'hCAFE_0002, 1, 7, "R6");
        issue(32'h104, 1, 32'h1234_5678, 32'h1234_5678, 0, 7, "R6");
        drain();
        // R8 back-pressure on a hit response
        rsp_ready = 1'b0;
        issue(32'h104, 0, '0, 32'h1234_5678, 1, 7, "R8");
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b1, "R8", "response held", rsp_valid, 1);
        check(rsp_data == 32'h1234_5678, "R8", "held data", rsp_data, 32'h1234_5678);
        check(rsp_hit == 1'b1, "R8", "held hit", rsp_hit, 1);
        check(req_ready == 1'b0, "R7", "ready low while response waits", req_ready, 0);
        rsp_ready = 1'b1;
        drain();
        // R1 reset invalidates all lines
        do_reset();
        issue(32'h104, 0, '0, mem_word(32'h104), 0, 8, "R1");
        issue(32'h00,  0, '0, mem_word(32'h0),   0, 9, "R1");
        issue(32'h104, 0, '0, mem_word(32'h104), 1, 9, "R4");
        drain();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected 0 pending", exp_data_q.size());
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule